// File: doc/BRIEF.md
# Pixel Histogram and Cumulative Accumulator

This block counts pixel values into a bin memory with one entry per possible pixel value. While the active-low frame input `start_n` is held low, the operation select `op` picks one of three write functions. Histogram mode adds one to the bin named by each valid pixel. Accumulate mode walks the bins upward from bin 0, keeps a running total and writes each partial total back, so the memory ends up holding the cumulative distribution. Clear mode walks the bins the same way and writes zero to each.

When `start_n` is high the block issues no updates. It then serves as a lookup table: the pixel input is used as a read address, and the stored bin value appears on `rd_data` one clock later.

Each bin update is a two-step read-modify-write. If the same bin is updated on consecutive clocks, the value just written is forwarded to the next update, so runs of identical pixels are counted exactly. Sums clamp at the largest value a bin can hold.

Top module: `pixel_hist_accum`

## Requirements
- R1: With `start_n` high, the value of the bin addressed by `pix` appears on `rd_data` after the next rising clock edge, one clock of latency.
- R2: With `start_n` low, `op`=2'b00 (histogram) and `pix_vld` high, the bin addressed by `pix` increases by one at each clock.
- R3: Updates of the same bin on consecutive clocks, or alternating with another bin, are all counted, with none lost.
- R4: With `start_n` low and `op`=2'b01 (accumulate), one bin per clock is visited in ascending order from bin 0. Bin k receives the sum of the original bins 0..k. The walk stops after bin 2^AW−1 and does not repeat within the same low period of `start_n`.
- R5: With `start_n` low and `op`=2'b10 (clear), the same ascending walk writes zero to every bin.
- R6: The walk address returns to bin 0, and the running total to zero, only at the first clock at which `start_n` is sampled low. If `op` is changed to 2'b11 (hold, no operation) while `start_n` stays low, the walk pauses and later resumes where it stopped.
- R7: While `start_n` is high, `op` and `pix_vld` have no effect, and no bin changes.
- R8: Both histogram increments and accumulated sums saturate at 2^DW−1 and do not wrap.
- R9: After reset, `rd_data` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_n | input | 1 | Active-low frame; low enables updates, high selects lookup |
| op | input | 2 | 00 histogram, 01 accumulate, 10 clear, 11 hold |
| pix_vld | input | 1 | Pixel valid in histogram mode |
| pix | input | AW (10) | Pixel value / lookup address |
| rd_data | output | DW (24) | Registered bin read data |

## Verification
Two things can happen in the same cycle: the write-back of one bin update and the read of the next update. When both target the same bin, the read returns a stale value, so forwarding must supply the newly written one. This is provoked by runs of identical pixels, alternating pairs of pixels, and random pixels drawn from a narrow range so that repeats are frequent. The result is judged by reading every bin back through lookup mode and comparing it with a bench model that applies each requirement one transaction at a time. Saturation is exercised with a reduced bin width, so that a bin can reach its ceiling in a few thousand clocks.

// File: rtl/pixel_hist_accum.sv
module pixel_hist_accum #(
  parameter int AW = 10,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_n,
  input  logic [1:0]    op,
  input  logic          pix_vld,
  input  logic [AW-1:0] pix,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  localparam logic [DW-1:0] MAXV = '1;
  localparam logic [DW-1:0] ONE  = 1;
  localparam logic [AW-1:0] LAST = '1;
  localparam logic [1:0] OP_HIST = 2'b00, OP_ACC = 2'b01, OP_CLR = 2'b10;

  logic [DW-1:0] mem [DEPTH];
  logic          start_q, done;
  logic [AW-1:0] cnt;
  logic [DW-1:0] acc, rdq;
  logic          s2_vld, wb_vld;
  logic [1:0]    s2_op;
  logic [AW-1:0] s2_addr, wb_addr;
  logic [DW-1:0] wb_data;

  wire          first   = !start_n && start_q;
  wire          sweep   = (op == OP_ACC) || (op == OP_CLR);
  wire [AW-1:0] sw_addr = first ? '0 : cnt;
  wire          sw_go   = !start_n && sweep && (first || !done);
  wire          hi_go   = !start_n && (op == OP_HIST) && pix_vld;
  wire [AW-1:0] rd_addr = sw_go ? sw_addr : pix;

  wire [DW-1:0] oldv  = (wb_vld && wb_addr == s2_addr) ? wb_data : rdq;
  wire [DW:0]   sum   = {1'b0, (s2_op == OP_ACC) ? acc : ONE} + {1'b0, oldv};
  wire [DW-1:0] sat   = sum[DW] ? MAXV : sum[DW-1:0];
  wire [DW-1:0] wdata = (s2_op == OP_CLR) ? '0 : sat;

  assign rd_data = rdq;

  always_ff @(posedge clk)
    if (s2_vld) mem[s2_addr] <= wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b1;
      done    <= 1'b0;
      cnt     <= '0;
      acc     <= '0;
      rdq     <= '0;
      s2_vld  <= 1'b0;
      s2_op   <= OP_HIST;
      s2_addr <= '0;
      wb_vld  <= 1'b0;
      wb_addr <= '0;
      wb_data <= '0;
    end else begin
      start_q <= start_n;
      rdq     <= mem[rd_addr];
      s2_vld  <= sw_go || hi_go;
      s2_op   <= op;
      s2_addr <= rd_addr;
      wb_vld  <= s2_vld;
      wb_addr <= s2_addr;
      wb_data <= wdata;
      if (sw_go) begin
        cnt  <= sw_addr + 1'b1;
        done <= (sw_addr == LAST);
      end else if (first) begin
        cnt  <= '0;
        done <= 1'b0;
      end
      if (first) acc <= '0;
      else if (s2_vld && s2_op == OP_ACC) acc <= sat;
    end
  end

  p_cnt_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_n && start_q) |=> (cnt <= 1));
  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_n |=> (cnt == $past(cnt)));
  p_no_lookup_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s2_vld |-> $past(!start_n));
  p_no_wrap_hist_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_vld && s2_op == OP_HIST) |-> (wdata != '0));
  p_acc_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_vld && s2_op == OP_ACC) |-> (wdata >= acc));
endmodule

// File: tb/tb_pixel_hist_accum.sv
module tb_pixel_hist_accum;
  localparam int AW = 10;
  localparam int DW = 12;
  localparam int DEPTH = 1 << AW;
  localparam int MAXV = (1 << DW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, start_n = 1'b1, pix_vld = 1'b0;
  logic [1:0] op = 2'b11;
  logic [AW-1:0] pix = '0;
  logic [DW-1:0] rd_data;

  pixel_hist_accum #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .op(op),
    .pix_vld(pix_vld), .pix(pix), .rd_data(rd_data));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int model [DEPTH];
  int m_cnt = 0, m_acc = 0;
  bit m_done = 1'b0, m_startq = 1'b1;

  function automatic int satv(int v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit sn, bit [1:0] o, bit v, int p);
    bit first;
    int a;
    @(negedge clk);
    start_n = sn; op = o; pix_vld = v; pix = AW'(p);
    @(posedge clk);
    first = !sn && m_startq;
    if (first) m_acc = 0;
    if (!sn && (o == 2'b01 || o == 2'b10) && (first || !m_done)) begin
      a = first ? 0 : m_cnt;
      if (o == 2'b01) begin
        m_acc = satv(m_acc + model[a]);
        model[a] = m_acc;
      end else model[a] = 0;
      m_cnt = (a + 1) % DEPTH;
      m_done = (a == DEPTH - 1);
    end else begin
      if (first) begin m_cnt = 0; m_done = 1'b0; end
      if (!sn && o == 2'b00 && v) model[p] = satv(model[p] + 1);
    end
    m_startq = sn;
    #1;
  endtask

  task automatic verify_all(string tag);
    step(1'b1, 2'b11, 1'b0, 0);
    for (int a = 0; a < DEPTH; a++) begin
      step(1'b1, 2'b11, 1'b0, a);
      check(tag, int'(rd_data), model[a]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < DEPTH; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    #1 check("R9 reset rd_data", int'(rd_data), 0);
    @(negedge clk) rst_n = 1'b1;

    // R5: clear sweep
    for (int i = 0; i < DEPTH + 5; i++) step(1'b0, 2'b10, 1'b0, 0);
    verify_all("R5 clear");

    // R3: back-to-back identical and alternating pixels
    for (int i = 0; i < 5; i++) step(1'b0, 2'b00, 1'b1, 7);
    step(1'b0, 2'b00, 1'b1, 8); step(1'b0, 2'b00, 1'b1, 8);
    step(1'b0, 2'b00, 1'b1, 9); step(1'b0, 2'b00, 1'b1, 8);
    step(1'b1, 2'b11, 1'b0, 7);
    step(1'b1, 2'b11, 1'b0, 7); check("R3 run bin7", int'(rd_data), 5);
    step(1'b1, 2'b11, 1'b0, 8); check("R3 alt bin8", int'(rd_data), 3);
    // R1: latency, address change shows the new bin one clock later
    step(1'b1, 2'b11, 1'b0, 9); check("R1 lookup bin9", int'(rd_data), 1);

    // R2: random histogram with frequent repeats and gaps
    for (int i = 0; i < 3000; i++)
      step(1'b0, 2'b00, 1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 63)));
    verify_all("R2 random histogram");

    // R7: start_n high, stimulus must be ignored
    for (int i = 0; i < 200; i++)
      step(1'b1, 2'($urandom_range(0, 3)), 1'b1, int'($urandom_range(0, 63)));
    verify_all("R7 ignored when high");

    // R4 + R6: accumulate with a hold pause mid-walk, then extra cycles
    for (int i = 0; i < 300; i++) step(1'b0, 2'b01, 1'b0, 0);
    for (int i = 0; i < 5; i++)   step(1'b0, 2'b11, 1'b0, 0);
    for (int i = 0; i < 800; i++) step(1'b0, 2'b01, 1'b0, 0);
    verify_all("R4 R6 accumulate pause");

    // R6: partial walk, release, relaunch from bin 0
    step(1'b1, 2'b11, 1'b0, 0);
    for (int i = 0; i < 10; i++) step(1'b0, 2'b10, 1'b0, 0);
    step(1'b1, 2'b11, 1'b0, 0); step(1'b1, 2'b11, 1'b0, 0);
    for (int i = 0; i < 20; i++) step(1'b0, 2'b00, 1'b1, int'($urandom_range(0, 15)));
    step(1'b1, 2'b11, 1'b0, 0);
    for (int i = 0; i < DEPTH + 3; i++) step(1'b0, 2'b01, 1'b0, 0);
    verify_all("R6 restart walk");

    // R8: saturation of increments and of sums
    step(1'b1, 2'b11, 1'b0, 0);
    for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 2'b10, 1'b0, 0);
    for (int i = 0; i < MAXV + 5; i++) step(1'b0, 2'b00, 1'b1, 5);
    for (int i = 0; i < 4000; i++) step(1'b0, 2'b00, 1'b1, 6);
    step(1'b1, 2'b11, 1'b0, 5);
    step(1'b1, 2'b11, 1'b0, 5); check("R8 hist clamp", int'(rd_data), MAXV);
    for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 2'b01, 1'b0, 0);
    verify_all("R8 sum clamp");
    step(1'b1, 2'b11, 1'b0, 6);
    step(1'b1, 2'b11, 1'b0, 6); check("R8 bin6 clamp", int'(rd_data), MAXV);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule